// File: doc/BRIEF.md
# Single-Adder Operand-Conditioning ALU

This block is the arithmetic unit of a small accumulator machine. It has no clock. One binary adder produces every result. A conditioning stage in front of the adder sets up each function. That stage can force the left operand to zero, force the right operand to zero, or complement the right operand, and it also sets the adder's carry-in. The block therefore needs no separate subtractor, incrementer or bypass path. Sum, difference, program-counter step and load/branch pass-through all come from the same carry chain.

The left operand is taken from the accumulator or from the program counter. The right operand is taken from memory read data or from the instruction register. In the second case only the low 12-bit address field is used, zero-extended to 16 bits. A 2-bit function code selects the operation. The block also returns a zero flag and a sign flag for conditional branches. The surrounding control unit owns the registers and the fetch/execute sequencing.

Top module: `opc_alu`

## Requirements
- R1: Left-source select `lsel` = 0 takes the accumulator input as X; `lsel` = 1 takes the program-counter input.
- R2: Right-source select `rsel` = 1 takes memory read data as Y. `rsel` = 0 takes bits [11:0] of the instruction input, zero-extended to 16 bits.
- R3: Function code 2'b00 gives `res` = (X + Y) mod 2^16.
- R4: Function code 2'b01 gives `res` = (X − Y) mod 2^16, the true two's-complement difference.
- R5: Function code 2'b10 gives `res` = (X + 1) mod 2^16. Y has no effect.
- R6: Function code 2'b11 gives `res` = Y. X has no effect.
- R7: `zf` is 1 exactly when `res` is all zeros.
- R8: `nf` always equals bit 15 of `res`.
- R9: Bits [15:12] of the instruction input never affect any output.
- R10: Results wrap without error: 0xFFFF + 1 gives 0x0000 with `zf` = 1, and 0 − 1 gives 0xFFFF with `nf` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| acc_in | input | 16 | Accumulator value |
| pc_in | input | 16 | Program-counter value |
| ir_in | input | 16 | Instruction register; low 12 bits are the address field |
| mem_in | input | 16 | Memory read data |
| lsel | input | 1 | X source: 0 accumulator, 1 program counter |
| rsel | input | 1 | Y source: 0 address field, 1 memory data |
| fn | input | 2 | 00 add, 01 subtract, 10 increment, 11 pass Y |
| res | output | 16 | Adder result |
| zf | output | 1 | Result is zero |
| nf | output | 1 | Result sign bit |

## Verification
The hardest case to reach from the ports is a carry or borrow that runs the full length of the chain. This is where a wrong carry-in or a missing complement shows up. Random operands almost never produce it. The stimulus therefore drives it on purpose with directed vectors: all-ones plus one, zero minus one, equal operands subtracted, and a 0x7FFF/0x8000 sign crossover. These are applied through both X sources. Address-field vectors are also run with the upper instruction bits set, to show that those bits are masked.

// File: rtl/opc_alu_pkg.sv
package opc_alu_pkg;

    localparam int DATA_W = 16;
    localparam int ADDR_W = 12;

    typedef enum logic [1:0] {
        FN_ADD  = 2'b00,
        FN_SUB  = 2'b01,
        FN_INC  = 2'b10,
        FN_PASS = 2'b11
    } alu_fn_e;

    typedef struct packed {
        logic clr_x;
        logic clr_y;
        logic cpl_y;
        logic cin;
    } cond_ctl_t;

endpackage

// File: rtl/opc_operand_mux.sv
module opc_operand_mux #(
    parameter int DW = 16,
    parameter int AW = 12
) (
    input  logic [DW-1:0] acc_v,
    input  logic [DW-1:0] pc_v,
    input  logic [AW-1:0] addr_v,
    input  logic [DW-1:0] mem_v,
    input  logic          lsel,
    input  logic          rsel,
    output logic [DW-1:0] x_bus,
    output logic [DW-1:0] y_bus
);
    localparam int PAD_W = DW - AW;

    logic [DW-1:0] addr_ext;

    generate
        if (PAD_W > 0) begin : g_pad
            assign addr_ext = {{PAD_W{1'b0}}, addr_v};
        end else begin : g_nopad
            assign addr_ext = addr_v[DW-1:0];
        end
    endgenerate

    always_comb begin
        x_bus = lsel ? pc_v  : acc_v;
        y_bus = rsel ? mem_v : addr_ext;
    end
endmodule

// File: rtl/opc_precond.sv
module opc_precond
    import opc_alu_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic [1:0]    fn_code,
    input  logic [DW-1:0] x_bus,
    input  logic [DW-1:0] y_bus,
    output logic [DW-1:0] x_cond,
    output logic [DW-1:0] y_cond,
    output logic          cin
);
    cond_ctl_t ctl;
    alu_fn_e   fn_e;
    logic [DW-1:0] y_mid;

    assign fn_e = alu_fn_e'(fn_code);

    always_comb begin
        unique case (fn_e)
            FN_ADD:  ctl = '{clr_x: 1'b0, clr_y: 1'b0, cpl_y: 1'b0, cin: 1'b0};
            FN_SUB:  ctl = '{clr_x: 1'b0, clr_y: 1'b0, cpl_y: 1'b1, cin: 1'b1};
            FN_INC:  ctl = '{clr_x: 1'b0, clr_y: 1'b1, cpl_y: 1'b0, cin: 1'b1};
            FN_PASS: ctl = '{clr_x: 1'b1, clr_y: 1'b0, cpl_y: 1'b0, cin: 1'b0};
            default: ctl = '{clr_x: 1'b0, clr_y: 1'b0, cpl_y: 1'b0, cin: 1'b0};
        endcase
    end

    always_comb begin
        x_cond = ctl.clr_x ? '0 : x_bus;
        y_mid  = ctl.clr_y ? '0 : y_bus;
        y_cond = ctl.cpl_y ? ~y_mid : y_mid;
        cin    = ctl.cin;
    end
endmodule

// File: rtl/opc_adder.sv
module opc_adder #(
    parameter int DW     = 16,
    parameter bit RIPPLE = 1'b1
) (
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic          cin,
    output logic [DW-1:0] sum
);
    generate
        if (RIPPLE) begin : g_ripple
            logic [DW-1:0] cy;
            assign cy[0] = cin;
            for (genvar i = 0; i < DW; i++) begin : g_bit
                assign sum[i] = a[i] ^ b[i] ^ cy[i];
                if (i < DW - 1) begin : g_cy
                    assign cy[i+1] = (a[i] & b[i]) | (cy[i] & (a[i] ^ b[i]));
                end
            end
        end else begin : g_behav
            assign sum = a + b + {{(DW-1){1'b0}}, cin};
        end
    endgenerate
endmodule

// File: rtl/opc_flags.sv
module opc_flags #(
    parameter int DW = 16
) (
    input  logic [DW-1:0] value,
    output logic          is_zero,
    output logic          is_neg
);
    always_comb begin
        is_zero = ~|value;
        is_neg  = value[DW-1];
    end
endmodule

// File: rtl/opc_alu.sv
module opc_alu
    import opc_alu_pkg::*;
(
    input  logic [DATA_W-1:0] acc_in,
    input  logic [DATA_W-1:0] pc_in,
    input  logic [DATA_W-1:0] ir_in,
    input  logic [DATA_W-1:0] mem_in,
    input  logic              lsel,
    input  logic              rsel,
    input  logic [1:0]        fn,
    output logic [DATA_W-1:0] res,
    output logic              zf,
    output logic              nf
);
    logic [DATA_W-1:0] x_bus, y_bus, x_cond, y_cond;
    logic              cin;
    logic              unused_ir_hi;

    assign unused_ir_hi = ^ir_in[DATA_W-1:ADDR_W];

    opc_operand_mux #(.DW(DATA_W), .AW(ADDR_W)) u_mux (
        .acc_v (acc_in),
        .pc_v  (pc_in),
        .addr_v(ir_in[ADDR_W-1:0]),
        .mem_v (mem_in),
        .lsel  (lsel),
        .rsel  (rsel),
        .x_bus (x_bus),
        .y_bus (y_bus)
    );

    opc_precond #(.DW(DATA_W)) u_cond (
        .fn_code(fn),
        .x_bus  (x_bus),
        .y_bus  (y_bus),
        .x_cond (x_cond),
        .y_cond (y_cond),
        .cin    (cin)
    );

    opc_adder #(.DW(DATA_W), .RIPPLE(1'b1)) u_add (
        .a  (x_cond),
        .b  (y_cond),
        .cin(cin),
        .sum(res)
    );

    opc_flags #(.DW(DATA_W)) u_flg (
        .value  (res),
        .is_zero(zf),
        .is_neg (nf)
    );
endmodule

// File: rtl/opc_alu_chk.sv
module opc_alu_chk
    import opc_alu_pkg::*;
(
    input logic [DATA_W-1:0] acc_in,
    input logic [DATA_W-1:0] pc_in,
    input logic [DATA_W-1:0] ir_in,
    input logic [DATA_W-1:0] mem_in,
    input logic              lsel,
    input logic              rsel,
    input logic [1:0]        fn,
    input logic [DATA_W-1:0] res,
    input logic              zf,
    input logic              nf
);
    logic [DATA_W-1:0] xv, yv;

    always_comb begin
        xv = lsel ? pc_in : acc_in;
        yv = rsel ? mem_in : {{(DATA_W-ADDR_W){1'b0}}, ir_in[ADDR_W-1:0]};
        if (fn == 2'b00) AST_ADD_SUM:  assert (res == DATA_W'(xv + yv));     // R3
        if (fn == 2'b01) AST_SUB_DIFF: assert (res == DATA_W'(xv - yv));     // R4
        if (fn == 2'b10) AST_INC_STEP: assert (res == DATA_W'(xv + 1'b1));   // R5
        if (fn == 2'b11) AST_PASS_Y:   assert (res == yv);                   // R6
        AST_ZERO_FLAG: assert (zf == (res == '0));                            // R7
        AST_NEG_FLAG:  assert (nf == res[DATA_W-1]);                          // R8
    end
endmodule

bind opc_alu opc_alu_chk u_chk (
    .acc_in(acc_in),
    .pc_in (pc_in),
    .ir_in (ir_in),
    .mem_in(mem_in),
    .lsel  (lsel),
    .rsel  (rsel),
    .fn    (fn),
    .res   (res),
    .zf    (zf),
    .nf    (nf)
);

// File: tb/opc_alu_test.sv
module opc_alu_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] acc_in = '0, pc_in = '0, ir_in = '0, mem_in = '0;
    logic        lsel = 1'b0, rsel = 1'b0;
    logic [1:0]  fn = 2'b00;
    logic [15:0] res;
    logic        zf, nf;

    int n_vec  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    opc_alu uut (
        .acc_in(acc_in), .pc_in(pc_in), .ir_in(ir_in), .mem_in(mem_in),
        .lsel(lsel), .rsel(rsel), .fn(fn),
        .res(res), .zf(zf), .nf(nf)
    );

    function automatic int model_res(int a, int p, int ir, int m,
                                     bit ls, bit rs, int f);
        int x;
        int y;
        x = ls ? p : a;
        y = rs ? m : (ir % 4096);
        case (f)
            0: return (x + y) % 65536;
            1: return (x - y + 65536) % 65536;
            2: return (x + 1) % 65536;
            default: return y;
        endcase
    endfunction

    task automatic apply(input int a, input int p, input int ir, input int m,
                         input bit ls, input bit rs, input int f,
                         input string req);
        int e;
        bit ez;
        bit en;
        @(posedge clk);
        acc_in = a[15:0]; pc_in = p[15:0]; ir_in = ir[15:0]; mem_in = m[15:0];
        lsel = ls; rsel = rs; fn = f[1:0];
        @(negedge clk);
        e  = model_res(a, p, ir, m, ls, rs, f);
        ez = (e == 0);
        en = (e >= 32768);
        n_vec++;
        if (int'(res) != e || zf != ez || nf != en) begin
            n_fail++;
            $display("FAIL %s: res=%h zf=%b nf=%b expected res=%h zf=%b nf=%b",
                     req, res, zf, nf, e[15:0], ez, en);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (2) @(posedge clk);
        rst = 1'b0;
        // quiescent state: all inputs zero, add gives zero result
        apply(0, 0, 0, 0, 0, 0, 0, "R7 idle zero");
        // R1 source selection
        apply(16'h1234, 16'h0100, 0, 1, 0, 1, 0, "R1 acc as X");
        apply(16'h1234, 16'h0100, 0, 1, 1, 1, 0, "R1 pc as X");
        // R2 address field zero-extended
        apply(16'h0010, 0, 16'h0ABC, 16'h7777, 0, 0, 0, "R2 addr field");
        apply(16'h0010, 0, 16'h0ABC, 16'h7777, 0, 1, 0, "R2 mem data");
        // R3 add
        apply(16'h4000, 0, 0, 16'h3FFF, 0, 1, 0, "R3 add");
        apply(16'h8000, 0, 0, 16'h8000, 0, 1, 0, "R3 add wrap to zero");
        // R4 subtract
        apply(16'h0500, 0, 0, 16'h0123, 0, 1, 1, "R4 sub");
        apply(16'h5A5A, 0, 0, 16'h5A5A, 0, 1, 1, "R4 equal operands");
        apply(16'h7FFF, 0, 0, 16'hFFFF, 0, 1, 1, "R4 sign crossover");
        // R5 increment ignores Y
        apply(0, 16'h0041, 0, 16'hFFFF, 1, 1, 2, "R5 pc step");
        apply(0, 16'h7FFF, 16'hFFF, 0, 1, 0, 2, "R5 step to negative");
        // R6 pass ignores X
        apply(16'hFFFF, 16'hFFFF, 0, 16'h8001, 1, 1, 3, "R6 pass mem");
        apply(16'hABCD, 0, 16'h0123, 0, 0, 0, 3, "R6 pass addr");
        // R9 upper instruction bits masked
        apply(0, 0, 16'hF456, 0, 0, 0, 3, "R9 ir high bits pass");
        apply(16'h0001, 0, 16'hF000, 0, 0, 0, 1, "R9 ir high bits sub");
        // R10 wrap corners
        apply(16'hFFFF, 0, 0, 16'h0001, 0, 1, 0, "R10 ffff+1");
        apply(0, 16'hFFFF, 0, 0, 1, 1, 2, "R10 pc ffff inc");
        apply(0, 0, 0, 16'h0001, 0, 1, 1, "R10 zero minus one");
        apply(0, 16'h0000, 16'h0001, 0, 1, 0, 1, "R10 pc zero minus one");
        // R7 R8 flags across random operands, all functions and sources
        for (int k = 0; k < 600; k++) begin
            apply(int'($urandom % 65536), int'($urandom % 65536),
                  int'($urandom % 65536), int'($urandom % 65536),
                  bit'($urandom % 2), bit'($urandom % 2), int'($urandom % 4),
                  "R3 R4 R5 R6 R7 R8 random");
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end
endmodule